// File: doc/BRIEF.md
# Decimal-Word Accumulator Processor

This block is a small stored-program processor built around one accumulator. Programs and data sit together in an internal memory of 100 signed words. Each word is stored in binary but is read as a decimal value in the range -9999 to +9999. An instruction word is split in decimal: the instruction divided by 100 gives the operation code, and the remainder gives the operand address. The control sequencer moves through fetch, decode, operand read and execute. It offers load, store, the four arithmetic operations plus remainder, three kinds of jump, a terminal input handshake, a terminal output handshake, and a stop.

The surrounding logic holds `rst_n` low and writes the program image through the load port. It then releases reset, and execution starts at address 0. The processor stops in one of two terminal states. A clean stop raises `halted`. Any illegal condition raises `fault` with a cause code. In both states the program counter, instruction register and accumulator stay frozen for inspection until the next reset.

Top module: `dec_acc_core`

## Requirements
- R1: The load port writes memory only while `rst_n` is low. During reset `pc` and `acc` read 0, and `halted`, `fault`, `in_req` and `out_valid` are all low. After release, execution begins at address 0.
- R2: An instruction word splits into operation = word / 100 and address = word mod 100. A fetched word that is negative or above 9999 gives fault code 4. In that case `ir` shows the word and `pc` is not advanced.
- R3: After add (30), subtract (31), multiply (33) or divide (32), a result above +9999 gives fault code 1 and a result below -9999 gives fault code 2. On either fault the accumulator keeps its previous value.
- R4: Divide (32) or remainder (34) by a zero operand gives fault code 3, and the accumulator is left unchanged.
- R5: Divide truncates toward zero. Remainder (34) takes the sign of the dividend and never raises a range fault.
- R6: Jump (40) always loads `pc` with the operand address. Jump-if-negative (41) does so only when the accumulator is below zero, and jump-if-zero (42) only when it equals zero. A target at or beyond the memory size gives fault code 5.
- R7: An operation code outside {0, 10, 11, 20, 21, 30-34, 40-43} gives fault code 4.
- R8: A fetch with `pc` at or beyond 100 gives fault code 5, and `pc` shows the failing value.
- R9: Input (10) raises `in_req` until `in_valid` is seen with `in_data` in -9999..+9999. That value is written to the operand address. An out-of-range value is ignored and the wait continues.
- R10: Output (11) raises `out_valid` with the operand word on `out_data`. Both hold steady until `out_ready` is seen high, and each word is delivered exactly once.
- R11: Operation 43 and operation 0 both stop execution with `halted` high. `pc` then points one past the stop instruction.
- R12: `halted` and `fault` are terminal until reset, and `pc`, `ir`, `acc` and `fault_code` do not change while either is high. `fault_code` is nonzero exactly when `fault` is high.
- R13: Load (20) copies the operand word into the accumulator. Store (21) writes the accumulator to the operand address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; load window while low |
| ld_we | input | 1 | Load-port write enable (honoured only in reset) |
| ld_addr | input | 7 | Load-port word address |
| ld_data | input | 16 | Load-port signed word |
| in_req | output | 1 | Processor waits for a terminal input word |
| in_valid | input | 1 | Terminal input word present |
| in_data | input | 16 | Signed terminal input word |
| out_valid | output | 1 | Terminal output word present |
| out_ready | input | 1 | Terminal accepts the output word |
| out_data | output | 16 | Signed terminal output word |
| halted | output | 1 | Clean stop reached |
| fault | output | 1 | Illegal condition reached |
| fault_code | output | 3 | 1 overflow, 2 underflow, 3 zero divisor, 4 bad instruction, 5 bad address |
| pc | output | 7 | Program counter |
| ir | output | 16 | Instruction register |
| acc | output | 16 | Accumulator |

## Verification
The range property on the accumulator assumes that every word the loader writes and later reaches the accumulator through a load lies within ±9999. Only words that serve as instructions are allowed outside that range. The bench follows this rule: it places out-of-range words only at instruction addresses, to provoke the bad-instruction fault. The output-hold property assumes that `out_ready` may drop at any time. The bench therefore stalls the output handshake for several cycles. Input words are offered only while `in_req` is high, and the one deliberately out-of-range input is withdrawn after a single cycle.

// File: rtl/dec_core_pkg.sv
// Shared types for the decimal-word accumulator processor.
// Assumes operation codes fit in 7 bits (decimal split leaves 0..99).
package dec_core_pkg;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_DECODE,
        ST_OPERAND,
        ST_EXEC,
        ST_INPUT,
        ST_OUTPUT,
        ST_STOP,
        ST_FAULT
    } seq_state_e;

    typedef enum logic [2:0] {
        FLT_NONE  = 3'd0,
        FLT_OVER  = 3'd1,
        FLT_UNDER = 3'd2,
        FLT_DIVZ  = 3'd3,
        FLT_INSN  = 3'd4,
        FLT_ADDR  = 3'd5
    } fault_e;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_MUL,
        ALU_DIV,
        ALU_MOD
    } alu_op_e;

    localparam logic [6:0] OPC_NOP_STOP = 7'd0;
    localparam logic [6:0] OPC_IN       = 7'd10;
    localparam logic [6:0] OPC_OUT      = 7'd11;
    localparam logic [6:0] OPC_LOAD     = 7'd20;
    localparam logic [6:0] OPC_STORE    = 7'd21;
    localparam logic [6:0] OPC_ADD      = 7'd30;
    localparam logic [6:0] OPC_SUB      = 7'd31;
    localparam logic [6:0] OPC_DIV      = 7'd32;
    localparam logic [6:0] OPC_MUL      = 7'd33;
    localparam logic [6:0] OPC_MOD      = 7'd34;
    localparam logic [6:0] OPC_JMP      = 7'd40;
    localparam logic [6:0] OPC_JNEG     = 7'd41;
    localparam logic [6:0] OPC_JZERO    = 7'd42;
    localparam logic [6:0] OPC_STOP     = 7'd43;

endpackage

// File: rtl/dec_word_mem.sv
// Word memory: one synchronous write port, one registered read port.
// Assumes addresses at or beyond DEPTH are filtered; such reads return 0
// and such writes are dropped.
module dec_word_mem #(
    parameter int DEPTH  = 100,
    parameter int WIDTH  = 16,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WIDTH-1:0]  rdata
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    logic [WIDTH-1:0] cells [DEPTH];

    // Store a word when enabled and the address is inside the array.
    always_ff @(posedge clk) begin
        if (we && (waddr <= LAST)) begin
            cells[waddr] <= wdata;
        end
    end

    // Register the read word; out-of-array reads give zero.
    always_ff @(posedge clk) begin
        if (raddr <= LAST) begin
            rdata <= cells[raddr];
        end else begin
            rdata <= '0;
        end
    end

endmodule

// File: rtl/dec_insn_split.sv
// Instruction splitter: separates a word into operation (word / SPLIT)
// and operand address (word mod SPLIT), and flags words outside 0..LIM.
// Assumes SPLIT squared exceeds LIM so the operation fits in 7 bits.
module dec_insn_split #(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 7,
    parameter int LIM    = 9999,
    parameter int SPLIT  = 100
) (
    input  logic signed [WORD_W-1:0] word,
    output logic [6:0]               opc,
    output logic [ADDR_W-1:0]        addr,
    output logic                     word_ok
);

    localparam logic signed [WORD_W-1:0] LIM_W   = WORD_W'(LIM);
    localparam logic        [WORD_W-1:0] SPLIT_W = WORD_W'(SPLIT);

    logic [WORD_W-1:0] mag;

    // Decimal split of the word into its two fields.
    always_comb begin
        mag     = word;
        opc     = 7'(mag / SPLIT_W);
        addr    = ADDR_W'(mag % SPLIT_W);
        word_ok = !word[WORD_W-1] && (word <= LIM_W);
    end

endmodule

// File: rtl/dec_alu.sv
// Arithmetic unit: add, subtract, multiply, divide, remainder on signed
// words, with a doubled-width intermediate and a ±LIM range check.
// Assumes operands are already within ±LIM.
module dec_alu
    import dec_core_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int LIM    = 9999
) (
    input  alu_op_e                  op,
    input  logic signed [WORD_W-1:0] a,
    input  logic signed [WORD_W-1:0] b,
    output logic signed [WORD_W-1:0] res,
    output fault_e                   flt
);

    localparam int WW = 2 * WORD_W;
    localparam logic signed [WW-1:0] HI = WW'(LIM);
    localparam logic signed [WW-1:0] LO = -HI;

    logic signed [WW-1:0] wa;
    logic signed [WW-1:0] wb;
    logic signed [WW-1:0] wr;
    logic                 range_chk;

    // Compute the wide result and classify any fault.
    always_comb begin
        wa        = WW'(a);
        wb        = WW'(b);
        wr        = '0;
        flt       = FLT_NONE;
        range_chk = 1'b1;
        case (op)
            ALU_ADD: wr = wa + wb;
            ALU_SUB: wr = wa - wb;
            ALU_MUL: wr = wa * wb;
            ALU_DIV: begin
                if (wb == '0) begin
                    flt       = FLT_DIVZ;
                    range_chk = 1'b0;
                end else begin
                    wr = wa / wb;
                end
            end
            default: begin
                range_chk = 1'b0;
                if (wb == '0) begin
                    flt = FLT_DIVZ;
                end else begin
                    wr = wa % wb;
                end
            end
        endcase
        if (range_chk && (wr > HI)) begin
            flt = FLT_OVER;
        end else if (range_chk && (wr < LO)) begin
            flt = FLT_UNDER;
        end
        res = wr[WORD_W-1:0];
    end

endmodule

// File: rtl/dec_acc_core.sv
// Decimal-word accumulator processor: sequencer, registers and terminal
// handshakes around an internal word memory.
// Assumes the program is written through the load port while rst_n is low;
// execution starts at address 0 after release.
module dec_acc_core
    import dec_core_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int MEM_DEPTH = 100,
    parameter int WORD_LIM  = 9999,
    parameter int OPC_SPLIT = 100,
    parameter int ADDR_W    = $clog2(MEM_DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ld_we,
    input  logic [ADDR_W-1:0]        ld_addr,
    input  logic signed [WORD_W-1:0] ld_data,
    output logic                     in_req,
    input  logic                     in_valid,
    input  logic signed [WORD_W-1:0] in_data,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic signed [WORD_W-1:0] out_data,
    output logic                     halted,
    output logic                     fault,
    output logic [2:0]               fault_code,
    output logic [ADDR_W-1:0]        pc,
    output logic signed [WORD_W-1:0] ir,
    output logic signed [WORD_W-1:0] acc
);

    localparam logic [ADDR_W-1:0]        DEPTH_A = ADDR_W'(MEM_DEPTH);
    localparam logic signed [WORD_W-1:0] LIM_W   = WORD_W'(WORD_LIM);

    seq_state_e               state_q;
    logic [ADDR_W-1:0]        pc_q;
    logic signed [WORD_W-1:0] ir_q;
    logic signed [WORD_W-1:0] acc_q;
    logic signed [WORD_W-1:0] opval_q;
    logic [6:0]               opc_q;
    logic [ADDR_W-1:0]        oaddr_q;
    fault_e                   fcode_q;

    logic [WORD_W-1:0]        mem_rdata;
    logic [ADDR_W-1:0]        mem_raddr;
    logic                     mem_we;
    logic [ADDR_W-1:0]        mem_waddr;
    logic [WORD_W-1:0]        mem_wdata;
    logic                     core_we;
    logic [WORD_W-1:0]        core_wdata;

    logic [6:0]               dec_opc;
    logic [ADDR_W-1:0]        dec_addr;
    logic                     dec_ok;

    alu_op_e                  alu_op;
    logic signed [WORD_W-1:0] alu_res;
    fault_e                   alu_flt;

    logic                     in_ok;
    logic                     jump_take;

    dec_word_mem #(
        .DEPTH  (MEM_DEPTH),
        .WIDTH  (WORD_W),
        .ADDR_W (ADDR_W)
    ) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    dec_insn_split #(
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W),
        .LIM    (WORD_LIM),
        .SPLIT  (OPC_SPLIT)
    ) u_split (
        .word    (mem_rdata),
        .opc     (dec_opc),
        .addr    (dec_addr),
        .word_ok (dec_ok)
    );

    dec_alu #(
        .WORD_W (WORD_W),
        .LIM    (WORD_LIM)
    ) u_alu (
        .op  (alu_op),
        .a   (acc_q),
        .b   (opval_q),
        .res (alu_res),
        .flt (alu_flt)
    );

    // Pick the arithmetic operation from the latched operation code.
    always_comb begin
        case (opc_q)
            OPC_SUB: alu_op = ALU_SUB;
            OPC_MUL: alu_op = ALU_MUL;
            OPC_DIV: alu_op = ALU_DIV;
            OPC_MOD: alu_op = ALU_MOD;
            default: alu_op = ALU_ADD;
        endcase
    end

    // Decide whether a jump instruction transfers control.
    always_comb begin
        case (opc_q)
            OPC_JMP:   jump_take = 1'b1;
            OPC_JNEG:  jump_take = acc_q[WORD_W-1];
            OPC_JZERO: jump_take = (acc_q == '0);
            default:   jump_take = 1'b0;
        endcase
    end

    // Memory port steering: loader during reset, processor otherwise.
    always_comb begin
        in_ok      = (in_data <= LIM_W) && (in_data >= -LIM_W);
        mem_raddr  = (state_q == ST_FETCH) ? pc_q : dec_addr;
        core_we    = ((state_q == ST_EXEC) && (opc_q == OPC_STORE)) ||
                     ((state_q == ST_INPUT) && in_valid && in_ok);
        core_wdata = (state_q == ST_INPUT) ? in_data : acc_q;
        mem_we     = rst_n ? core_we : ld_we;
        mem_waddr  = rst_n ? oaddr_q : ld_addr;
        mem_wdata  = rst_n ? core_wdata : ld_data;
    end

    // Sequencer and architectural registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
            pc_q    <= '0;
            ir_q    <= '0;
            acc_q   <= '0;
            opval_q <= '0;
            opc_q   <= '0;
            oaddr_q <= '0;
            fcode_q <= FLT_NONE;
        end else begin
            case (state_q)
                ST_FETCH: begin
                    if (pc_q >= DEPTH_A) begin
                        fcode_q <= FLT_ADDR;
                        state_q <= ST_FAULT;
                    end else begin
                        state_q <= ST_DECODE;
                    end
                end
                ST_DECODE: begin
                    ir_q <= mem_rdata;
                    if (!dec_ok) begin
                        fcode_q <= FLT_INSN;
                        state_q <= ST_FAULT;
                    end else begin
                        opc_q   <= dec_opc;
                        oaddr_q <= dec_addr;
                        pc_q    <= pc_q + 1'b1;
                        state_q <= ST_OPERAND;
                    end
                end
                ST_OPERAND: begin
                    opval_q <= mem_rdata;
                    state_q <= ST_EXEC;
                end
                ST_EXEC: begin
                    state_q <= ST_FETCH;
                    case (opc_q)
                        OPC_NOP_STOP, OPC_STOP: state_q <= ST_STOP;
                        OPC_IN:    state_q <= ST_INPUT;
                        OPC_OUT:   state_q <= ST_OUTPUT;
                        OPC_LOAD:  acc_q   <= opval_q;
                        OPC_STORE: ;
                        OPC_ADD, OPC_SUB, OPC_MUL, OPC_DIV, OPC_MOD: begin
                            if (alu_flt != FLT_NONE) begin
                                fcode_q <= alu_flt;
                                state_q <= ST_FAULT;
                            end else begin
                                acc_q <= alu_res;
                            end
                        end
                        OPC_JMP, OPC_JNEG, OPC_JZERO: begin
                            if (jump_take) begin
                                if (oaddr_q >= DEPTH_A) begin
                                    fcode_q <= FLT_ADDR;
                                    state_q <= ST_FAULT;
                                end else begin
                                    pc_q <= oaddr_q;
                                end
                            end
                        end
                        default: begin
                            fcode_q <= FLT_INSN;
                            state_q <= ST_FAULT;
                        end
                    endcase
                end
                ST_INPUT: begin
                    if (in_valid && in_ok) begin
                        state_q <= ST_FETCH;
                    end
                end
                ST_OUTPUT: begin
                    if (out_ready) begin
                        state_q <= ST_FETCH;
                    end
                end
                default: state_q <= state_q;
            endcase
        end
    end

    // Drive the visible ports from the registers.
    always_comb begin
        in_req     = (state_q == ST_INPUT);
        out_valid  = (state_q == ST_OUTPUT);
        out_data   = opval_q;
        halted     = (state_q == ST_STOP);
        fault      = (state_q == ST_FAULT);
        fault_code = fcode_q;
        pc         = pc_q;
        ir         = ir_q;
        acc        = acc_q;
    end

endmodule

// File: rtl/dec_acc_core_chk.sv
// Property checker for the decimal-word accumulator processor, attached
// by bind. Assumes loaded data words lie within ±WORD_LIM.
module dec_acc_core_chk #(
    parameter int WORD_W    = 16,
    parameter int ADDR_W    = 7,
    parameter int MEM_DEPTH = 100,
    parameter int WORD_LIM  = 9999
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_req,
    input logic                     out_valid,
    input logic                     out_ready,
    input logic signed [WORD_W-1:0] out_data,
    input logic                     halted,
    input logic                     fault,
    input logic [2:0]               fault_code,
    input logic [ADDR_W-1:0]        pc,
    input logic signed [WORD_W-1:0] ir,
    input logic signed [WORD_W-1:0] acc
);

    localparam logic signed [WORD_W-1:0] LIM_W   = WORD_W'(WORD_LIM);
    localparam logic [ADDR_W-1:0]        DEPTH_A = ADDR_W'(MEM_DEPTH);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc <= LIM_W) && (acc >= -LIM_W));

    p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_stop_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc) && $stable(acc) && $stable(ir)));

    p_fault_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (fault && $stable(pc) && $stable(acc) && $stable(ir) &&
                   $stable(fault_code)));

    p_code_iff_fault_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code != 3'd0) == fault);

    p_one_terminal_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({halted, fault, in_req, out_valid}));

    p_pc_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pc <= DEPTH_A);

endmodule

bind dec_acc_core dec_acc_core_chk #(
    .WORD_W    (WORD_W),
    .ADDR_W    (ADDR_W),
    .MEM_DEPTH (MEM_DEPTH),
    .WORD_LIM  (WORD_LIM)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_req     (in_req),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .halted     (halted),
    .fault      (fault),
    .fault_code (fault_code),
    .pc         (pc),
    .ir         (ir),
    .acc        (acc)
);

// File: tb/tb_dec_acc_core.sv
// Scoreboard bench: each program pushes its expected output words into a
// queue; a monitor pops and compares them as the processor emits them.
module tb_dec_acc_core;

    localparam int W  = 16;
    localparam int AW = 7;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                ld_we = 1'b0;
    logic [AW-1:0]       ld_addr = '0;
    logic signed [W-1:0] ld_data = '0;
    logic                in_req;
    logic                in_valid = 1'b0;
    logic signed [W-1:0] in_data = '0;
    logic                out_valid;
    logic                out_ready = 1'b1;
    logic signed [W-1:0] out_data;
    logic                halted;
    logic                fault;
    logic [2:0]          fault_code;
    logic [AW-1:0]       pc;
    logic signed [W-1:0] ir;
    logic signed [W-1:0] acc;

    int n_checks = 0;
    int n_err    = 0;
    int exp_q[$];
    int in_q[$];

    always #10 clk = ~clk;

    dec_acc_core dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_we      (ld_we),
        .ld_addr    (ld_addr),
        .ld_data    (ld_data),
        .in_req     (in_req),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .halted     (halted),
        .fault      (fault),
        .fault_code (fault_code),
        .pc         (pc),
        .ir         (ir),
        .acc        (acc)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic exp_push(input int v);
        exp_q.push_back(v);
    endtask

    // Monitor: compare each accepted output word against the scoreboard (R10).
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                n_checks++;
                n_err++;
                $display("FAIL R10 unexpected output: actual %0d expected none",
                         int'(out_data));
            end else begin
                check("R10 output word", int'(out_data), exp_q.pop_front());
            end
        end
    end

    // Input responder: offer queued words while the processor requests one.
    always @(posedge clk) begin
        #1;
        if (in_req && in_q.size() > 0) begin
            in_valid = 1'b1;
            in_data  = W'(in_q[0]);
        end else begin
            in_valid = 1'b0;
        end
    end

    // Retire an offered input word once it has been seen by an edge.
    always @(negedge clk) begin
        if (in_req && in_valid && in_q.size() > 0) begin
            void'(in_q.pop_front());
        end
    end

    task automatic poke(input int a, input int v);
        ld_we   = 1'b1;
        ld_addr = AW'(a);
        ld_data = W'(v);
        @(posedge clk);
        #1;
        ld_we = 1'b0;
    endtask

    task automatic begin_prog();
        rst_n = 1'b0;
        exp_q.delete();
        in_q.delete();
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic run_prog(input string req);
        bit done;
        done = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        for (int i = 0; i < 4000 && !done; i++) begin
            @(negedge clk);
            done = halted || fault;
        end
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL %s no stop: actual running expected stopped", req);
        end
    endtask

    task automatic expect_end(input string req, input int exp_halt,
                              input int exp_code, input int exp_pc,
                              input int exp_acc, input int exp_ir);
        int pc0;
        int acc0;
        pc0  = int'(pc);
        acc0 = int'(acc);
        repeat (6) @(negedge clk);
        check({req, " halted"}, int'(halted), exp_halt);
        check({req, " fault"}, int'(fault), (exp_code != 0) ? 1 : 0);
        check({req, " fault_code"}, int'(fault_code), exp_code);
        check({req, " pc"}, int'(pc), exp_pc);
        check({req, " acc"}, int'(acc), exp_acc);
        check({req, " ir"}, int'(ir), exp_ir);
        check("R12 pc frozen", int'(pc), pc0);
        check("R12 acc frozen", int'(acc), acc0);
        check({req, " all outputs seen"}, exp_q.size(), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20 * 150000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        check("R1 reset pc", int'(pc), 0);
        check("R1 reset acc", int'(acc), 0);
        check("R1 reset flags", int'({halted, fault, in_req, out_valid}), 0);

        // R5 / R13 / R11: arithmetic chain with outputs, clean stop by 43.
        begin_prog();
        poke(0, 2020); poke(1, 3021); poke(2, 2122); poke(3, 1122);
        poke(4, 3123); poke(5, 3321); poke(6, 2124); poke(7, 1124);
        poke(8, 3220); poke(9, 2125); poke(10, 1125); poke(11, 3421);
        poke(12, 2126); poke(13, 1126); poke(14, 4300);
        poke(20, 7); poke(21, 5); poke(23, 30);
        exp_push(12); exp_push(-90); exp_push(-12); exp_push(-2);
        run_prog("R5");
        expect_end("R11", 1, 0, 15, -2, 4300);
        check("R13 load/store result in acc", int'(acc), -2);

        // R6: countdown loop with zero and negative jumps, stop on opcode 0.
        begin_prog();
        poke(0, 2030); poke(1, 4207); poke(2, 1130); poke(3, 3131);
        poke(4, 2130); poke(5, 4001); poke(7, 3131); poke(8, 4110);
        poke(9, 4300); poke(10, 2132); poke(11, 1132); poke(12, 0);
        poke(30, 3); poke(31, 1);
        exp_push(3); exp_push(2); exp_push(1); exp_push(-1);
        run_prog("R6");
        expect_end("R6", 1, 0, 13, -1, 0);

        // R3: overflow on multiply.
        begin_prog();
        poke(0, 2010); poke(1, 3310); poke(10, 9999);
        run_prog("R3");
        expect_end("R3 overflow", 0, 1, 2, 9999, 3310);

        // R3: underflow on subtract.
        begin_prog();
        poke(0, 2010); poke(1, 3111); poke(10, -9999); poke(11, 1);
        run_prog("R3");
        expect_end("R3 underflow", 0, 2, 2, -9999, 3111);

        // R4: divide by zero.
        begin_prog();
        poke(0, 2010); poke(1, 3211); poke(10, 7); poke(11, 0);
        run_prog("R4");
        expect_end("R4 divide", 0, 3, 2, 7, 3211);

        // R4: remainder by zero.
        begin_prog();
        poke(0, 2010); poke(1, 3411); poke(10, 7); poke(11, 0);
        run_prog("R4");
        expect_end("R4 remainder", 0, 3, 2, 7, 3411);

        // R7: unknown operation code 50.
        begin_prog();
        poke(0, 5000);
        run_prog("R7");
        expect_end("R7", 0, 4, 1, 0, 5000);

        // R2: instruction word above 9999.
        begin_prog();
        poke(0, 12345);
        run_prog("R2");
        expect_end("R2", 0, 4, 0, 0, 12345);

        // R8: program runs off the end of memory.
        begin_prog();
        poke(0, 4099); poke(99, 2010); poke(10, 8);
        run_prog("R8");
        expect_end("R8", 0, 5, 100, 8, 2010);

        // R9 / R10: input with one ignored out-of-range word, stalled output.
        begin_prog();
        poke(0, 1050); poke(1, 1150); poke(2, 4300); poke(50, 7);
        in_q.push_back(12000);
        in_q.push_back(42);
        exp_push(42);
        out_ready = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        for (int i = 0; i < 200 && !out_valid; i++) @(negedge clk);
        repeat (4) @(negedge clk);
        check("R10 stall holds out_valid", int'(out_valid), 1);
        check("R10 stall no stop", int'(halted), 0);
        check("R9 inputs consumed", in_q.size(), 0);
        @(posedge clk);
        #1;
        out_ready = 1'b1;
        for (int i = 0; i < 200 && !halted; i++) @(negedge clk);
        expect_end("R9", 1, 0, 3, 0, 4300);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule